// File: doc/BRIEF.md
# I2C Status Flags and DMA Request Generator

This block holds the eight-bit status word of a byte-oriented I2C controller and decides when to ask a DMA engine for service. The shift engine and the address comparator report events to it as single-cycle pulses. These events are a finished byte together with its acknowledge slot, a match on the own address, and a lost arbitration. The shift engine and comparator also drive level signals: bus busy, range match, slave direction and the received acknowledge bit. The register file reports its accesses as strobes: a read or write of the data register, a write of the control register, and a write of the status register with its data byte.

Each sticky flag has its own clearing rule. The transfer flag clears as a side effect of a data register access, and which access clears it depends on whether the controller is transmitting or receiving. The addressed flag clears on any control write. The arbitration and interrupt-pending flags clear only when 1 is written to their bit positions. The DMA request is a combinational pulse in the same cycle as the event that causes it. In fast-acknowledge mode, only transmitted bytes raise a request.

Top module: `i2c_stat_dma`

## Requirements
- R1: The status word, from bit 7 down to bit 0, is: transfer done, addressed, bus busy, arbitration lost, range match, slave read, interrupt pending, received NACK. After reset it reads 8'h80.
- R2: A byte-complete pulse or an address-match pulse sets transfer done (bit 7) on the next cycle. An address match also sets addressed (bit 6).
- R3: Transfer done clears after a data read while in receive mode (mode_tx=0), or after a data write while in transmit mode (mode_tx=1). A data write in receive mode leaves it set, and so does a data read in transmit mode.
- R4: Any control register write clears addressed, whatever data is written.
- R5: Writing the status register with bit 4 or bit 1 set clears arbitration lost or interrupt pending, respectively. A 0 in those positions leaves the flag unchanged. For every sticky flag, a set event in the same cycle as a clear takes priority.
- R6: Interrupt pending (bit 1) sets on a byte completion, an address match or an arbitration loss. The irq output equals interrupt pending ANDed with irq_en.
- R7: Bus busy, range match, slave read and received NACK show the values of their inputs one cycle later.
- R8: With dma_en=1 and fast_ack=0, dma_req is high in the same cycle as every byte-complete pulse, in either direction, and every address-match pulse.
- R9: With dma_en=1 and fast_ack=1, dma_req is high only in the same cycle as a byte-complete pulse with byte_tx=1.
- R10: With dma_en=0, dma_req stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| byte_done | input | 1 | Pulse: byte and acknowledge slot finished |
| byte_tx | input | 1 | Direction of the finished byte, 1 = transmitted |
| addr_hit | input | 1 | Pulse: first received byte matched own or general call address |
| arb_lost | input | 1 | Pulse: arbitration lost |
| bus_busy | input | 1 | Level: bus busy |
| range_hit | input | 1 | Level: address fell in the range window |
| slave_rd | input | 1 | Level: master requested a read |
| nack_rx | input | 1 | Level: last acknowledge slot read high |
| dat_rd | input | 1 | Strobe: data register read |
| dat_wr | input | 1 | Strobe: data register write |
| ctl_wr | input | 1 | Strobe: control register write |
| st_wr | input | 1 | Strobe: status register write |
| wdata | input | 8 | Write data for the status register |
| mode_tx | input | 1 | Controller transmit mode |
| fast_ack | input | 1 | Fast-acknowledge mode |
| dma_en | input | 1 | DMA enable |
| irq_en | input | 1 | Interrupt enable |
| status | output | 8 | Status word |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA request pulse |

## Verification
The assertions assume that byte_done, addr_hit and arb_lost are one-cycle pulses, and that byte_tx carries meaning only while byte_done is high. Under those assumptions, each clear rule can be checked one cycle after its strobe whenever no set event shares that cycle. The stimulus drives every input at the falling edge and lowers each pulse after exactly one cycle. It combines set events with clear strobes only in the scenario that tests priority.

// File: rtl/i2c_stat_dma.sv
module i2c_stat_dma (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       byte_done,
  input  logic       byte_tx,
  input  logic       addr_hit,
  input  logic       arb_lost,
  input  logic       bus_busy,
  input  logic       range_hit,
  input  logic       slave_rd,
  input  logic       nack_rx,
  input  logic       dat_rd,
  input  logic       dat_wr,
  input  logic       ctl_wr,
  input  logic       st_wr,
  input  logic [7:0] wdata,
  input  logic       mode_tx,
  input  logic       fast_ack,
  input  logic       dma_en,
  input  logic       irq_en,
  output logic [7:0] status,
  output logic       irq,
  output logic       dma_req
);

  logic done_q, addr_q, busy_q, arb_q, range_q, srd_q, pend_q, nack_q;

  logic done_clr, arb_clr, pend_clr, pend_set;
  assign done_clr = (dat_rd & ~mode_tx) | (dat_wr & mode_tx);
  assign arb_clr  = st_wr & wdata[4];
  assign pend_clr = st_wr & wdata[1];
  assign pend_set = byte_done | addr_hit | arb_lost;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q  <= 1'b1;
      addr_q  <= 1'b0;
      busy_q  <= 1'b0;
      arb_q   <= 1'b0;
      range_q <= 1'b0;
      srd_q   <= 1'b0;
      pend_q  <= 1'b0;
      nack_q  <= 1'b0;
    end else begin
      if (byte_done | addr_hit) done_q <= 1'b1;
      else if (done_clr)        done_q <= 1'b0;
      if (addr_hit)             addr_q <= 1'b1;
      else if (ctl_wr)          addr_q <= 1'b0;
      if (arb_lost)             arb_q  <= 1'b1;
      else if (arb_clr)         arb_q  <= 1'b0;
      if (pend_set)             pend_q <= 1'b1;
      else if (pend_clr)        pend_q <= 1'b0;
      busy_q  <= bus_busy;
      range_q <= range_hit;
      srd_q   <= slave_rd;
      nack_q  <= nack_rx;
    end
  end

  assign status  = {done_q, addr_q, busy_q, arb_q, range_q, srd_q, pend_q, nack_q};
  assign irq     = pend_q & irq_en;
  assign dma_req = dma_en & (fast_ack ? (byte_done & byte_tx) : (byte_done | addr_hit));

  p_done_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done | addr_hit) |=> status[7]);
  p_addr_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    addr_hit |=> status[6]);
  p_done_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_rd & !mode_tx & !byte_done & !addr_hit) |=> !status[7]);
  p_addr_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr & !addr_hit) |=> !status[6]);
  p_arb_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr & !wdata[4] & !arb_lost) |=> (status[4] == $past(status[4])));
  p_pend_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    arb_lost |=> status[1]);
  p_fast_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_ack & dma_req) |-> (byte_done & byte_tx));
  p_dma_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_en |-> !dma_req);

endmodule

// File: tb/i2c_stat_dma_tb.sv
module i2c_stat_dma_tb;
  logic clk = 0, rst_n = 0;
  logic byte_done = 0, byte_tx = 0, addr_hit = 0, arb_lost = 0;
  logic bus_busy = 0, range_hit = 0, slave_rd = 0, nack_rx = 0;
  logic dat_rd = 0, dat_wr = 0, ctl_wr = 0, st_wr = 0;
  logic [7:0] wdata = 0;
  logic mode_tx = 0, fast_ack = 0, dma_en = 0, irq_en = 0;
  logic [7:0] status;
  logic irq, dma_req;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  i2c_stat_dma u_dut (.*);

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic idle();
    byte_done = 0; byte_tx = 0; addr_hit = 0; arb_lost = 0;
    dat_rd = 0; dat_wr = 0; ctl_wr = 0; st_wr = 0; wdata = 0;
  endtask

  task automatic tick();
    @(negedge clk); idle();
  endtask

  task automatic t_reset_r1();
    chk("R1 reset", status, 8'h80);
    chk("R1 irq", {7'd0, irq}, 8'd0);
  endtask

  task automatic t_set_r2();
    @(negedge clk); mode_tx = 1; dat_wr = 1; tick();
    chk("R3 tx write clears", status, 8'h00);
    @(negedge clk); byte_done = 1; tick();
    chk("R2 byte sets done", status & 8'hC0, 8'h80);
    @(negedge clk); mode_tx = 0; dat_rd = 1; tick();
    @(negedge clk); addr_hit = 1; tick();
    chk("R2 addr sets both", status & 8'hC0, 8'hC0);
  endtask

  task automatic t_clr_r3();
    @(negedge clk); mode_tx = 0; dat_wr = 1; tick();
    chk("R3 rx write keeps", status & 8'h80, 8'h80);
    @(negedge clk); mode_tx = 1; dat_rd = 1; tick();
    chk("R3 tx read keeps", status & 8'h80, 8'h80);
    @(negedge clk); mode_tx = 0; dat_rd = 1; tick();
    chk("R3 rx read clears", status & 8'h80, 8'h00);
  endtask

  task automatic t_ctl_r4();
    chk("R4 pre", status & 8'h40, 8'h40);
    @(negedge clk); ctl_wr = 1; wdata = 8'h00; tick();
    chk("R4 ctl write clears", status & 8'h40, 8'h00);
  endtask

  task automatic t_w1c_r5();
    @(negedge clk); arb_lost = 1; tick();
    chk("R5 arb set", status & 8'h12, 8'h12);
    @(negedge clk); st_wr = 1; wdata = 8'hED; tick();
    chk("R5 write zeros keeps", status & 8'h12, 8'h12);
    @(negedge clk); st_wr = 1; wdata = 8'h10; tick();
    chk("R5 clear arb only", status & 8'h12, 8'h02);
    @(negedge clk); st_wr = 1; wdata = 8'h02; tick();
    chk("R5 clear pend", status & 8'h12, 8'h00);
    @(negedge clk); arb_lost = 1; st_wr = 1; wdata = 8'h12; tick();
    chk("R5 set wins", status & 8'h12, 8'h12);
    @(negedge clk); addr_hit = 1; ctl_wr = 1; mode_tx = 0; dat_rd = 1; tick();
    chk("R5 set wins addr", status & 8'hC0, 8'hC0);
    @(negedge clk); st_wr = 1; wdata = 8'h12; ctl_wr = 1; tick();
  endtask

  task automatic t_irq_r6();
    irq_en = 1;
    chk("R6 irq idle", {7'd0, irq}, 8'd0);
    @(negedge clk); byte_done = 1; tick();
    chk("R6 byte pend", status & 8'h02, 8'h02);
    chk("R6 irq on", {7'd0, irq}, 8'd1);
    irq_en = 0; #1;
    chk("R6 irq gated", {7'd0, irq}, 8'd0);
    @(negedge clk); st_wr = 1; wdata = 8'h02; tick();
  endtask

  task automatic t_level_r7();
    @(negedge clk); bus_busy = 1; range_hit = 0; slave_rd = 1; nack_rx = 0; #1;
    chk("R7 not yet", status & 8'h2D, 8'h00);
    @(negedge clk);
    chk("R7 mirror a", status & 8'h2D, 8'h24);
    bus_busy = 0; range_hit = 1; slave_rd = 0; nack_rx = 1;
    @(negedge clk);
    chk("R7 mirror b", status & 8'h2D, 8'h09);
    range_hit = 0; nack_rx = 0;
  endtask

  task automatic t_dma();
    dma_en = 1; fast_ack = 0;
    @(negedge clk); byte_done = 1; byte_tx = 0; #1;
    chk("R8 rx byte", {7'd0, dma_req}, 8'd1);
    byte_tx = 1; #1;
    chk("R8 tx byte", {7'd0, dma_req}, 8'd1);
    tick(); #1;
    chk("R8 pulse ends", {7'd0, dma_req}, 8'd0);
    addr_hit = 1; #1;
    chk("R8 addr", {7'd0, dma_req}, 8'd1);
    fast_ack = 1; #1;
    chk("R9 addr no req", {7'd0, dma_req}, 8'd0);
    tick(); byte_done = 1; byte_tx = 0; #1;
    chk("R9 rx no req", {7'd0, dma_req}, 8'd0);
    byte_tx = 1; #1;
    chk("R9 tx req", {7'd0, dma_req}, 8'd1);
    dma_en = 0; #1;
    chk("R10 tx off", {7'd0, dma_req}, 8'd0);
    fast_ack = 0; byte_tx = 0; #1;
    chk("R10 rx off", {7'd0, dma_req}, 8'd0);
    tick(); addr_hit = 1; #1;
    chk("R10 addr off", {7'd0, dma_req}, 8'd0);
    tick();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_r1();
    rst_n = 1;
    @(negedge clk);
    t_reset_r1();
    t_set_r2();
    t_clr_r3();
    t_ctl_r4();
    t_w1c_r5();
    t_irq_r6();
    t_level_r7();
    t_dma();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule